// File: doc/BRIEF.md
# Buck Startup Sequencer

This block is the digital sequencer that takes a synchronous step-down converter from enable to steady-state switching. It watches a small set of comparator flags (feedback above the soft-start level, feedback above the power-good fraction, low-side current beyond the sink limit, inductor current at zero), a decoded three-level mode select and the PWM comparator's high-side request. From these it drives the high-side and low-side gate enables, a code for the low-side sink-current limit DAC, and a phase indicator.

In the monotonic modes both switches stay off until feedback crosses the soft-start level, so a prebiased output is not pulled down. Switching always begins with a single low-side cycle that charges the bootstrap capacitor. The sink limit then ramps through four DAC steps, and the selected steady mode takes over a fixed number of cycles after feedback is first seen above the power-good fraction. In skip mode the low side is released at zero crossing and pulsed briefly after a long idle stretch to keep the bootstrap charged.

Top module: `bsq_seq_top`

## Requirements
- R1: `mode_sel_i` encoding: 2'b00 plain forced PWM, 2'b01 and 2'b11 forced PWM with monotonic startup, 2'b10 skip with monotonic startup. In plain mode the edge that first samples enable moves straight to the bootstrap cycle without waiting for `fb_ss_i`.
- R2: In every monotonic mode (including skip) both gate enables stay low and `phase_o` reads 1 while `fb_ss_i` has not yet been sampled high.
- R3: The first switching cycle (after enable in plain mode, after `fb_ss_i` in monotonic modes) lasts one cycle with the low side on, the high side off and `sink_code_o` at 0.
- R4: `sink_code_o` equals min(3, floor(k/32)), k being the number of clock edges since the bootstrap cycle, so the full code 3 is held from k = 96 and the whole ramp spans 128 cycles.
- R5: In soft-start and steady forced PWM the high side follows `pwm_req_i` of the previous cycle, the low side is on only when `pwm_req_i` was low and `ls_sink_i` was low, and `zero_x_i` has no effect.
- R6: In a monotonic soft-start, the 4096th edge counted from the first edge that samples `fb_pg_i` high hands off to the steady mode; the count continues if `fb_pg_i` drops.
- R7: `phase_o` encoding: 0 idle, 1 startup, 2 steady forced PWM, 3 steady skip. Plain mode enters phase 2 right after the bootstrap cycle; in steady state each edge selects skip for 2'b10 and forced PWM for any other code.
- R8: In skip mode the low side stays on after a high-side pulse until `zero_x_i` is sampled high, and is low in the cycle that follows.
- R9: In skip mode, after 8 consecutive cycles with both gate enables low, the low side is on for exactly one cycle.
- R10: A low `en_i` or high `fault_i` returns the block on the next edge to idle: both gates low, `sink_code_o` 0, `phase_o` 0, held while the condition lasts.
- R11: `hs_on_o` and `ls_on_o` are never high in the same cycle.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| fault_i | input | 1 | Any fault (thermal, undervoltage, hiccup) |
| mode_sel_i | input | 2 | Decoded three-level mode select |
| fb_ss_i | input | 1 | Feedback above the soft-start level |
| fb_pg_i | input | 1 | Feedback above the power-good fraction of the reference |
| ls_sink_i | input | 1 | Low-side current beyond the sink limit |
| zero_x_i | input | 1 | Inductor current at zero crossing |
| pwm_req_i | input | 1 | PWM comparator high-side request |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| sink_code_o | output | CODE_W (2) | Sink-current limit DAC code |
| phase_o | output | 2 | Operating phase indicator |

## Verification
The assertions watch every cycle for shoot-through, for the return to idle with a cleared DAC code after a disable or fault, for both switches off while waiting for soft-start, for the single low-side bootstrap cycle and for a DAC code that never steps down while switching. The exact ramp step positions, the 4096-cycle handoff edge, the skip-mode zero-crossing release and the nine-cycle refresh cadence depend on counted cycle positions, so only the bench's directed and random scenarios show them.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam logic [1:0] MSEL_PLAIN = 2'b00;
    localparam logic [1:0] MSEL_SKIP  = 2'b10;

    localparam logic [1:0] PH_IDLE  = 2'd0;
    localparam logic [1:0] PH_START = 2'd1;
    localparam logic [1:0] PH_FPWM  = 2'd2;
    localparam logic [1:0] PH_SKIP  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_PRECHG = 3'd2,
        ST_SOFT   = 3'd3,
        ST_FPWM   = 3'd4,
        ST_SKIP   = 3'd5
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    mono;
        logic    hs;
        logic    ls;
    } seq_reg_t;

    function automatic logic is_switching(input seq_st_e s);
        return (s == ST_PRECHG) || (s == ST_SOFT) || (s == ST_FPWM) || (s == ST_SKIP);
    endfunction

endpackage

// File: rtl/bsq_sink_ramp.sv
module bsq_sink_ramp #(
    parameter  int RAMP_CYC  = 128,
    parameter  int DAC_STEPS = 4,
    localparam int CODE_W    = $clog2(DAC_STEPS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              adv_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CNT_W    = $clog2(RAMP_CYC + 1);
    localparam int STEP_CYC = RAMP_CYC / DAC_STEPS;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RAMP_CYC);
    localparam logic [CNT_W-1:0] STEP_LEN = CNT_W'(STEP_CYC);
    localparam logic [CNT_W-1:0] TOP_IDX  = CNT_W'(DAC_STEPS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, step_idx;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        step_idx = cnt_q / STEP_LEN;
        code_o   = (step_idx >= TOP_IDX) ? TOP_IDX[CODE_W-1:0] : step_idx[CODE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bsq_handoff_timer.sv
module bsq_handoff_timer #(
    parameter int HANDOFF_CYC = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic step_i,
    output logic run_o,
    output logic last_o
);
    localparam int CNT_W = $clog2(HANDOFF_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HANDOFF_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (step_i) cnt_d = cnt_q + CNT_W'(1);
    end

    assign run_o  = (cnt_q != '0);
    assign last_o = (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bsq_skip_gate.sv
module bsq_skip_gate #(
    parameter int IDLE_LIM = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic pwm_req_i,
    input  logic zero_x_i,
    output logic hs_o,
    output logic ls_o
);
    localparam int IDLE_W = $clog2(IDLE_LIM + 1);
    localparam logic [IDLE_W-1:0] LIM = IDLE_W'(IDLE_LIM);

    logic              armed_d, armed_q;
    logic [IDLE_W-1:0] idle_d, idle_q;

    always_comb begin
        hs_o    = pwm_req_i;
        ls_o    = 1'b0;
        armed_d = armed_q;
        idle_d  = idle_q;
        if (pwm_req_i) begin
            armed_d = 1'b1;
            idle_d  = '0;
        end else if (armed_q) begin
            // low side conducts until the inductor current reaches zero
            ls_o    = !zero_x_i;
            armed_d = !zero_x_i;
            idle_d  = zero_x_i ? IDLE_W'(1) : '0;
        end else if (idle_q >= LIM) begin
            // bootstrap refresh pulse
            ls_o   = 1'b1;
            idle_d = '0;
        end else begin
            idle_d = idle_q + IDLE_W'(1);
        end
        if (!active_i) begin
            armed_d = 1'b1;
            idle_d  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b1;
            idle_q  <= '0;
        end else begin
            armed_q <= armed_d;
            idle_q  <= idle_d;
        end
    end
endmodule

// File: rtl/bsq_seq_top.sv
module bsq_seq_top
    import bsq_pkg::*;
#(
    parameter  int RAMP_CYC    = 128,
    parameter  int DAC_STEPS   = 4,
    parameter  int HANDOFF_CYC = 4096,
    parameter  int IDLE_LIM    = 8,
    localparam int CODE_W      = $clog2(DAC_STEPS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              fault_i,
    input  logic [1:0]        mode_sel_i,
    input  logic              fb_ss_i,
    input  logic              fb_pg_i,
    input  logic              ls_sink_i,
    input  logic              zero_x_i,
    input  logic              pwm_req_i,
    output logic              hs_on_o,
    output logic              ls_on_o,
    output logic [CODE_W-1:0] sink_code_o,
    output logic [1:0]        phase_o
);
    seq_reg_t r_d, r_q;
    logic     abort;
    logic     ho_step, ho_clr, ho_run, ho_last;
    logic     ramp_clr, ramp_adv;
    logic     skip_act, skip_hs, skip_ls;

    always_comb begin
        r_d     = r_q;
        ho_step = 1'b0;
        abort   = !en_i || fault_i;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.mono = (mode_sel_i != MSEL_PLAIN);
                r_d.st   = (mode_sel_i == MSEL_PLAIN) ? ST_PRECHG : ST_HOLD;
            end
            ST_HOLD: begin
                if (fb_ss_i) r_d.st = ST_PRECHG;
            end
            ST_PRECHG: begin
                r_d.st = r_q.mono ? ST_SOFT : ST_FPWM;
            end
            ST_SOFT: begin
                if (fb_pg_i || ho_run) begin
                    ho_step = 1'b1;
                    if (ho_last) r_d.st = (mode_sel_i == MSEL_SKIP) ? ST_SKIP : ST_FPWM;
                end
            end
            ST_FPWM: begin
                if (mode_sel_i == MSEL_SKIP) r_d.st = ST_SKIP;
            end
            ST_SKIP: begin
                if (mode_sel_i != MSEL_SKIP) r_d.st = ST_FPWM;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (abort) begin
            r_d.st   = ST_IDLE;
            r_d.mono = 1'b0;
        end
        r_d.hs = 1'b0;
        r_d.ls = 1'b0;
        case (r_d.st)
            ST_PRECHG: r_d.ls = 1'b1;
            ST_SOFT, ST_FPWM: begin
                r_d.hs = pwm_req_i;
                r_d.ls = !pwm_req_i && !ls_sink_i;
            end
            ST_SKIP: begin
                r_d.hs = skip_hs;
                r_d.ls = skip_ls;
            end
            default: ;
        endcase
    end

    assign ramp_adv = is_switching(r_d.st);
    assign ramp_clr = (r_d.st == ST_PRECHG) || !ramp_adv;
    assign ho_clr   = (r_d.st != ST_SOFT);
    assign skip_act = (r_d.st == ST_SKIP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    bsq_sink_ramp #(.RAMP_CYC(RAMP_CYC), .DAC_STEPS(DAC_STEPS)) u_ramp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ramp_clr),
        .adv_i  (ramp_adv),
        .code_o (sink_code_o)
    );

    bsq_handoff_timer #(.HANDOFF_CYC(HANDOFF_CYC)) u_handoff (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ho_clr),
        .step_i (ho_step),
        .run_o  (ho_run),
        .last_o (ho_last)
    );

    bsq_skip_gate #(.IDLE_LIM(IDLE_LIM)) u_skip (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (skip_act),
        .pwm_req_i (pwm_req_i),
        .zero_x_i  (zero_x_i),
        .hs_o      (skip_hs),
        .ls_o      (skip_ls)
    );

    assign hs_on_o = r_q.hs;
    assign ls_on_o = r_q.ls;

    always_comb begin
        case (r_q.st)
            ST_HOLD, ST_PRECHG, ST_SOFT: phase_o = PH_START;
            ST_FPWM:                     phase_o = PH_FPWM;
            ST_SKIP:                     phase_o = PH_SKIP;
            default:                     phase_o = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker
    import bsq_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              fault_i,
    input logic              hs_on_i,
    input logic              ls_on_i,
    input logic [CODE_W-1:0] sink_code_i,
    input seq_st_e           st_i
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hs_on_i && ls_on_i)); // R11

    AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i || fault_i) |=> (st_i == ST_IDLE && !hs_on_i && !ls_on_i && sink_code_i == '0)); // R10

    AST_HOLD_BOTH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_HOLD) |-> (!hs_on_i && !ls_on_i)); // R2

    AST_BOOT_LOW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_PRECHG) |-> (ls_on_i && !hs_on_i && sink_code_i == '0)); // R3

    AST_BOOT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_PRECHG) |=> (st_i != ST_PRECHG)); // R3

    AST_CODE_NO_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_switching(st_i) && (st_i != ST_PRECHG) && is_switching($past(st_i)))
            |-> (sink_code_i >= $past(sink_code_i))); // R4
endmodule

bind bsq_seq_top bsq_checker #(.CODE_W(CODE_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .fault_i     (fault_i),
    .hs_on_i     (hs_on_o),
    .ls_on_i     (ls_on_o),
    .sink_code_i (sink_code_o),
    .st_i        (r_q.st)
);

// File: tb/bsq_seq_top_tb.sv
module bsq_seq_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, fault = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       fb_ss = 1'b0, fb_pg = 1'b0, sink = 1'b0, zx = 1'b0, pwm = 1'b0;
    logic       hs, ls;
    logic [1:0] code, phase;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    bsq_seq_top u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fault_i(fault), .mode_sel_i(mode),
        .fb_ss_i(fb_ss), .fb_pg_i(fb_pg), .ls_sink_i(sink), .zero_x_i(zx), .pwm_req_i(pwm),
        .hs_on_o(hs), .ls_on_o(ls), .sink_code_o(code), .phase_o(phase)
    );

    function automatic int exp_code(input int k);
        return (k / 32 > 3) ? 3 : k / 32;
    endfunction

    function automatic int exp_fpwm_ls(input logic p, input logic s);
        return (!p && !s) ? 1 : 0;
    endfunction

    function automatic int exp_steady_phase(input logic [1:0] m);
        return (m == 2'b10) ? 3 : 2;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic rand_pwm();
        pwm  = 1'($urandom() & 1);
        sink = 1'($urandom() & 1);
        zx   = 1'($urandom() & 1);
    endtask

    // soft-start with FB-good handoff; leaves the block in its steady mode
    task automatic soft_handoff(input string tag, input logic [1:0] m, input bit randomize_pwm);
        fb_pg = 1'b1;
        for (int j = 1; j <= 4096; j++) begin
            if (randomize_pwm) rand_pwm();
            tick();
            if (j == 1) fb_pg = 1'b0;
            if (randomize_pwm) begin
                chk("R5", "soft hs", int'(hs), int'(pwm));
                chk("R5", "soft ls", int'(ls), exp_fpwm_ls(pwm, sink));
            end
            if (j == 4095) chk(tag, "phase before handoff", int'(phase), 1);
            if (j == 4096) chk(tag, "phase at handoff", int'(phase), exp_steady_phase(m));
        end
    endtask

    initial begin
        int bad;
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R12", "reset hs", int'(hs), 0);
        chk("R12", "reset ls", int'(ls), 0);
        chk("R12", "reset code", int'(code), 0);
        chk("R12", "reset phase", int'(phase), 0);

        // plain forced PWM
        mode = 2'b00; en = 1'b1; pwm = 1'b1;
        tick();
        chk("R1", "plain skips hold, phase", int'(phase), 1);
        chk("R3", "boot ls", int'(ls), 1);
        chk("R3", "boot hs", int'(hs), 0);
        chk("R3", "boot code", int'(code), 0);
        tick();
        chk("R7", "plain enters fpwm", int'(phase), 2);
        chk("R5", "fpwm hs", int'(hs), 1);
        chk("R4", "code k=1", int'(code), 0);
        for (int k = 2; k <= 200; k++) begin
            rand_pwm();
            tick();
            chk("R4", "ramp code", int'(code), exp_code(k));
            chk("R5", "fpwm hs", int'(hs), int'(pwm));
            chk("R5", "fpwm ls (zero_x ignored)", int'(ls), exp_fpwm_ls(pwm, sink));
        end
        en = 1'b0;
        tick();
        chk("R10", "disable phase", int'(phase), 0);
        chk("R10", "disable gates", int'({hs, ls}), 0);
        chk("R10", "disable code", int'(code), 0);

        // monotonic forced PWM
        mode = 2'b01; en = 1'b1; fb_ss = 1'b0; sink = 1'b0; zx = 1'b0;
        for (int i = 0; i < 20; i++) begin
            pwm = 1'($urandom() & 1);
            tick();
            chk("R2", "hold phase", int'(phase), 1);
            chk("R2", "hold gates", int'({hs, ls}), 0);
        end
        fb_ss = 1'b1;
        tick();
        chk("R3", "mono boot ls", int'(ls), 1);
        chk("R3", "mono boot hs", int'(hs), 0);
        rand_pwm();
        tick();
        chk("R5", "soft first hs", int'(hs), int'(pwm));
        soft_handoff("R6", 2'b01, 1'b1);
        chk("R4", "code full after ramp", int'(code), 3);

        fault = 1'b1;
        tick();
        chk("R10", "fault phase", int'(phase), 0);
        chk("R10", "fault gates", int'({hs, ls}), 0);
        tick();
        chk("R10", "fault held", int'(phase), 0);

        // skip mode: still monotonic at startup
        mode = 2'b10; fb_ss = 1'b0; pwm = 1'b0; sink = 1'b0; zx = 1'b0;
        fault = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R2", "skip hold gates", int'({hs, ls}), 0);
            chk("R2", "skip hold phase", int'(phase), 1);
        end
        fb_ss = 1'b1;
        tick();
        chk("R3", "skip boot ls", int'(ls), 1);
        tick();
        soft_handoff("R6", 2'b10, 1'b0);
        pwm = 1'b1;
        tick();
        chk("R8", "skip hs pulse", int'({hs, ls}), 2);
        pwm = 1'b0;
        tick();
        chk("R8", "ls after pulse", int'({hs, ls}), 1);
        tick();
        chk("R8", "ls held before zero", int'(ls), 1);
        zx = 1'b1;
        tick();
        chk("R8", "ls off at zero crossing", int'(ls), 0);
        zx = 1'b0;
        for (int i = 0; i < 7; i++) begin
            tick();
            chk("R9", "idle gates", int'({hs, ls}), 0);
        end
        tick();
        chk("R9", "refresh pulse", int'({hs, ls}), 1);
        tick();
        chk("R9", "refresh single cycle", int'(ls), 0);

        mode = 2'b00;
        tick();
        chk("R7", "skip to fpwm", int'(phase), 2);
        mode = 2'b10;
        tick();
        chk("R7", "fpwm to skip", int'(phase), 3);
        mode = 2'b11;
        tick();
        chk("R7", "code 11 selects fpwm", int'(phase), 2);

        // random steady-state traffic
        bad = 0;
        for (int i = 0; i < 3000; i++) begin
            rand_pwm();
            mode = 2'($urandom() & 3);
            tick();
            if (hs && ls) bad++;
            chk("R7", "random steady phase", int'(phase), exp_steady_phase(mode));
        end
        chk("R11", "shoot-through cycles", bad, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule